// File: doc/BRIEF.md
# SIMT Warp Reconvergence Stack

This unit keeps the control-flow state of one 32-thread warp: the shared program counter, the mask of threads that currently execute, a 2-bit completion code for each thread, and a last-in-first-out stack of reconvergence records. Each record holds a resume PC, a thread mask and a record kind. When the active threads split on a conditional branch, the unit follows the taken side at once. It stores the other side's PC and mask for later. When the current path completes, it pops the newest record and resumes from it. Threads that have exited are removed from every mask it restores.

A sequencer drives four commands: launch a warp, resolve a branch with a per-thread condition vector, push an explicit record (for calls, break scopes, quad scopes and join points), and signal path completion with a completion code. Instruction fetch and the execution datapath sit outside this unit and consume its PC, active mask and stack status. The PC is a 22-bit word address, which is a 24-bit byte address with its two low bits forced to zero.

The controller has four states. IDLE means no warp is loaded. RUN means the warp executes. DRAIN means a popped record held no live thread, so the unit pops one record per cycle on its own. FAULT means the stack overflowed or underflowed. The transitions are: launch goes from any state to RUN. From RUN, a completion whose restored mask is empty goes to DRAIN. From RUN, an overflowing push or a completion on an empty stack goes to FAULT. From DRAIN, a record with live threads goes to RUN. From DRAIN, an empty stack goes to IDLE. IDLE and FAULT are left only by launch.

Top module: `warp_reconv_stack`

## Requirements
- R1: After reset, pc is 0, active_mask is 0, depth is 0, stack_empty is 1, overflow and underflow are 0, every thread_state field is 0, and running is 0.
- R2: A launch loads pc from launch_pc and active_mask from launch_mask. It empties the stack, clears both fault flags, sets every thread to state 0, and enters RUN.
- R3: A branch on which all active threads agree pushes nothing. Condition bits of inactive threads are ignored. If every active thread's bit is 1, pc becomes br_target. If none is 1, pc becomes br_next_pc. The mask is unchanged.
- R4: A divergent branch sets pc to br_target and the mask to the active threads with condition 1. It pushes a record {push_type, br_next_pc, active threads with condition 0}, and depth rises by one.
- R5: An explicit push stores {push_type, push_pc, current mask}, raises depth by one, and leaves pc and mask unchanged. Record kinds: 1 branch, 2 call, 3 call with limit, 4 prebreak, 5 quadon, 6 joinat.
- R6: A completion with a non-empty stack pops the newest record, and pc and mask come from it, in last-in-first-out order.
- R7: A completion with a non-zero done_kind writes that code into the state of the active threads only. The codes are 0 live, 1 break, 2 return, 3 exit. Thread t's code sits at thread_state[2t+1:2t]. A done_kind of 0 leaves all states unchanged.
- R8: A mask restored by a pop excludes every thread whose state is 3, counting codes written in the same cycle.
- R9: Popping a kind-2 or kind-3 record returns threads of its mask in state 2 to state 0. Popping a kind-4 record returns threads of its mask in state 1 to state 0.
- R10: A pop whose restored mask is empty enters DRAIN with active_mask 0. DRAIN pops one record per cycle, with pc following each record. It returns to RUN at the first record with a live thread, and goes to IDLE when the stack is empty.
- R11: A push (explicit or divergent) with depth equal to DEPTH stores nothing. It sets overflow, clears active_mask and enters FAULT.
- R12: A completion with an empty stack sets underflow, clears active_mask and enters FAULT. A set flag stays set until the next launch.
- R13: Commands have the priority launch > completion > branch > explicit push. In IDLE, DRAIN and FAULT, every command except launch is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| launch | input | 1 | Load a new warp |
| launch_pc | input | 22 | Start word address |
| launch_mask | input | 32 | Initial thread mask |
| br_valid | input | 1 | Resolve a conditional branch |
| br_cond | input | 32 | Per-thread branch outcome, 1 means taken |
| br_target | input | 22 | Taken-side word address |
| br_next_pc | input | 22 | Not-taken-side word address |
| push_valid | input | 1 | Push an explicit record |
| push_pc | input | 22 | Resume address of the explicit record |
| push_type | input | 3 | Record kind for any push this cycle |
| done_valid | input | 1 | Current path completes |
| done_kind | input | 2 | Completion code given to active threads |
| pc | output | 22 | Current word address |
| active_mask | output | 32 | Threads that execute |
| depth | output | $clog2(DEPTH+1) | Records on the stack |
| stack_empty | output | 1 | Depth is zero |
| stack_full | output | 1 | Depth equals DEPTH |
| overflow | output | 1 | Push attempted on a full stack |
| underflow | output | 1 | Completion attempted on an empty stack |
| thread_state | output | 64 | 2-bit completion code per thread |
| running | output | 1 | Controller is in RUN |

## Verification
The assertions assume that the commands are known values at every clock edge. They also assume that a launch supplies a mask, and that no thread is ever marked exited while still active except through a completion. Their branch and push properties are gated on RUN and on the absence of higher-priority commands, so same-cycle command combinations are covered only by the bench. The stimulus changes inputs only at falling edges. It uses record kinds 1 to 6 only, and holds each command for exactly one cycle. Multi-command cycles appear only in the cycles that exercise the priority order.

// File: rtl/warp_reconv_pkg.sv
package warp_reconv_pkg;
    parameter int unsigned LANES  = 32;
    parameter int unsigned PC_W   = 22;
    parameter int unsigned KIND_W = 3;
    parameter int unsigned CODE_W = 2;

    typedef enum logic [KIND_W-1:0] {
        ENT_NONE     = 3'd0,
        ENT_BRANCH   = 3'd1,
        ENT_CALL     = 3'd2,
        ENT_CALL_LIM = 3'd3,
        ENT_PREBRK   = 3'd4,
        ENT_QUADON   = 3'd5,
        ENT_JOINAT   = 3'd6,
        ENT_RSVD     = 3'd7
    } ent_kind_e;

    typedef enum logic [CODE_W-1:0] {
        TS_LIVE   = 2'd0,
        TS_BREAK  = 2'd1,
        TS_RETURN = 2'd2,
        TS_EXIT   = 2'd3
    } thr_code_e;

    typedef enum logic [1:0] {
        U_IDLE  = 2'd0,
        U_RUN   = 2'd1,
        U_DRAIN = 2'd2,
        U_FAULT = 2'd3
    } unit_state_e;

    typedef struct packed {
        logic [KIND_W-1:0] kind;
        logic [PC_W-1:0]   pc;
        logic [LANES-1:0]  mask;
    } stack_ent_t;
endpackage

// File: rtl/warp_reconv_lifo.sv
module warp_reconv_lifo
    import warp_reconv_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1),
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             push,
    input  logic             pop,
    input  stack_ent_t       push_ent,
    output stack_ent_t       top_ent,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    stack_ent_t       slots [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign full   = (cnt_q == CNT_W'(DEPTH));
    assign empty  = (cnt_q == '0);
    assign wr_idx = IDX_W'(cnt_q);
    assign rd_idx = IDX_W'(cnt_q - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (push && !full && !clear) begin
            slots[wr_idx] <= push_ent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (push && !full) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end else if (pop && !empty) begin
            cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    assign top_ent = empty ? '0 : slots[rd_idx];
    assign count   = cnt_q;
endmodule

// File: rtl/warp_reconv_thr.sv
module warp_reconv_thr
    import warp_reconv_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear_all,
    input  logic [LANES-1:0]        set_mask,
    input  logic [CODE_W-1:0]       set_code,
    input  logic                    pop_en,
    input  logic [KIND_W-1:0]       pop_kind,
    input  logic [LANES-1:0]        pop_mask,
    output logic [CODE_W*LANES-1:0] state_vec,
    output logic [LANES-1:0]        exit_after
);
    logic revive_ret;
    logic revive_brk;

    assign revive_ret = pop_en && ((pop_kind == ENT_CALL) || (pop_kind == ENT_CALL_LIM));
    assign revive_brk = pop_en && (pop_kind == ENT_PREBRK);

    for (genvar t = 0; t < LANES; t++) begin : g_lane
        logic [CODE_W-1:0] code_q;
        logic [CODE_W-1:0] code_set;
        logic [CODE_W-1:0] code_d;

        assign code_set = set_mask[t] ? set_code : code_q;

        always_comb begin
            code_d = code_set;
            if (pop_mask[t] &&
                ((revive_ret && code_set == TS_RETURN) ||
                 (revive_brk && code_set == TS_BREAK))) begin
                code_d = TS_LIVE;
            end
            if (clear_all) begin
                code_d = TS_LIVE;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                code_q <= TS_LIVE;
            end else begin
                code_q <= code_d;
            end
        end

        assign state_vec[CODE_W*t +: CODE_W] = code_q;
        assign exit_after[t] = (code_set == TS_EXIT);
    end
endmodule

// File: rtl/warp_reconv_stack.sv
module warp_reconv_stack
    import warp_reconv_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    launch,
    input  logic [PC_W-1:0]         launch_pc,
    input  logic [LANES-1:0]        launch_mask,
    input  logic                    br_valid,
    input  logic [LANES-1:0]        br_cond,
    input  logic [PC_W-1:0]         br_target,
    input  logic [PC_W-1:0]         br_next_pc,
    input  logic                    push_valid,
    input  logic [PC_W-1:0]         push_pc,
    input  logic [KIND_W-1:0]       push_type,
    input  logic                    done_valid,
    input  logic [CODE_W-1:0]       done_kind,
    output logic [PC_W-1:0]         pc,
    output logic [LANES-1:0]        active_mask,
    output logic [CNT_W-1:0]        depth,
    output logic                    stack_empty,
    output logic                    stack_full,
    output logic                    overflow,
    output logic                    underflow,
    output logic [CODE_W*LANES-1:0] thread_state,
    output logic                    running
);
    unit_state_e       st_q, st_d;
    logic [PC_W-1:0]   pc_q, pc_d;
    logic [LANES-1:0]  mask_q, mask_d;
    logic              ovf_q, ovf_d;
    logic              unf_q, unf_d;

    logic              lifo_push, lifo_pop, lifo_clear;
    stack_ent_t        push_ent, top_ent;
    logic [CNT_W-1:0]  lifo_cnt;
    logic              lifo_full, lifo_empty;

    logic [LANES-1:0]  set_mask;
    logic [LANES-1:0]  exit_after;
    logic [LANES-1:0]  restored;
    logic [LANES-1:0]  taken, not_taken;

    // completion codes are written only for a completion accepted in RUN
    assign set_mask  = (!launch && st_q == U_RUN && done_valid && done_kind != '0) ? mask_q : '0;
    assign restored  = top_ent.mask & ~exit_after;
    assign taken     = mask_q & br_cond;
    assign not_taken = mask_q & ~br_cond;

    warp_reconv_lifo #(.DEPTH(DEPTH)) u_lifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (lifo_clear),
        .push     (lifo_push),
        .pop      (lifo_pop),
        .push_ent (push_ent),
        .top_ent  (top_ent),
        .count    (lifo_cnt),
        .full     (lifo_full),
        .empty    (lifo_empty)
    );

    warp_reconv_thr u_thr (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_all  (lifo_clear),
        .set_mask   (set_mask),
        .set_code   (done_kind),
        .pop_en     (lifo_pop),
        .pop_kind   (top_ent.kind),
        .pop_mask   (top_ent.mask),
        .state_vec  (thread_state),
        .exit_after (exit_after)
    );

    // next state and datapath controls
    always_comb begin
        st_d       = st_q;
        pc_d       = pc_q;
        mask_d     = mask_q;
        ovf_d      = ovf_q;
        unf_d      = unf_q;
        lifo_push  = 1'b0;
        lifo_pop   = 1'b0;
        lifo_clear = 1'b0;
        push_ent   = '0;
        if (launch) begin
            st_d       = U_RUN;
            pc_d       = launch_pc;
            mask_d     = launch_mask;
            ovf_d      = 1'b0;
            unf_d      = 1'b0;
            lifo_clear = 1'b1;
        end else begin
            unique case (st_q)
                U_RUN: begin
                    if (done_valid) begin
                        if (lifo_empty) begin
                            unf_d  = 1'b1;
                            mask_d = '0;
                            st_d   = U_FAULT;
                        end else begin
                            lifo_pop = 1'b1;
                            pc_d     = top_ent.pc;
                            mask_d   = restored;
                            st_d     = (restored != '0) ? U_RUN : U_DRAIN;
                        end
                    end else if (br_valid) begin
                        if (taken == '0) begin
                            pc_d = br_next_pc;
                        end else if (not_taken == '0) begin
                            pc_d = br_target;
                        end else if (lifo_full) begin
                            ovf_d  = 1'b1;
                            mask_d = '0;
                            st_d   = U_FAULT;
                        end else begin
                            lifo_push = 1'b1;
                            push_ent  = '{kind: push_type, pc: br_next_pc, mask: not_taken};
                            pc_d      = br_target;
                            mask_d    = taken;
                        end
                    end else if (push_valid) begin
                        if (lifo_full) begin
                            ovf_d  = 1'b1;
                            mask_d = '0;
                            st_d   = U_FAULT;
                        end else begin
                            lifo_push = 1'b1;
                            push_ent  = '{kind: push_type, pc: push_pc, mask: mask_q};
                        end
                    end
                end
                U_DRAIN: begin
                    if (lifo_empty) begin
                        mask_d = '0;
                        st_d   = U_IDLE;
                    end else begin
                        lifo_pop = 1'b1;
                        pc_d     = top_ent.pc;
                        mask_d   = restored;
                        st_d     = (restored != '0) ? U_RUN : U_DRAIN;
                    end
                end
                U_IDLE: begin
                end
                U_FAULT: begin
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= U_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q   <= '0;
            mask_q <= '0;
            ovf_q  <= 1'b0;
            unf_q  <= 1'b0;
        end else begin
            pc_q   <= pc_d;
            mask_q <= mask_d;
            ovf_q  <= ovf_d;
            unf_q  <= unf_d;
        end
    end

    assign pc          = pc_q;
    assign active_mask = mask_q;
    assign depth       = lifo_cnt;
    assign stack_empty = lifo_empty;
    assign stack_full  = lifo_full;
    assign overflow    = ovf_q;
    assign underflow   = unf_q;
    assign running     = (st_q == U_RUN);
endmodule

// File: rtl/warp_reconv_stack_chk.sv
module warp_reconv_stack_chk
    import warp_reconv_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    launch,
    input logic                    br_valid,
    input logic [LANES-1:0]        br_cond,
    input logic                    push_valid,
    input logic                    done_valid,
    input logic [LANES-1:0]        active_mask,
    input logic [CNT_W-1:0]        depth,
    input logic                    stack_full,
    input logic                    overflow,
    input logic                    underflow,
    input logic [CODE_W*LANES-1:0] thread_state,
    input logic                    running
);
    logic [LANES-1:0] exit_vec;
    logic             run_cmd;

    for (genvar t = 0; t < LANES; t++) begin : g_exit
        assign exit_vec[t] = (thread_state[CODE_W*t +: CODE_W] == TS_EXIT);
    end

    assign run_cmd = running && !launch && !done_valid;

    // R11: depth never passes the capacity
    p_depth_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth) <= int'(DEPTH));

    // R3: agreeing branch leaves the stack alone
    p_uniform_no_push_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cmd && br_valid &&
         (((active_mask & br_cond) == '0) || ((active_mask & ~br_cond) == '0)))
        |=> depth == $past(depth));

    // R4: a branch never adds threads to the mask
    p_branch_narrows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cmd && br_valid) |=> ((active_mask & ~$past(active_mask)) == '0));

    // R8: an exited thread is never active
    p_exit_excluded_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exit_vec & active_mask) == '0);

    // R11: explicit push on a full stack raises overflow without storing
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cmd && !br_valid && push_valid && stack_full)
        |=> (overflow && depth == $past(depth)));

    // R12: a fault flag stays until launch
    p_underflow_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !launch) |=> underflow);

    // R11 R12: faulted warp executes nothing
    p_fault_mask_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow || underflow) |-> (active_mask == '0));

    // R13: outside RUN only draining may change the stack, and only downward
    p_idle_ignore_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !launch) |=> (depth <= $past(depth)));
endmodule

bind warp_reconv_stack warp_reconv_stack_chk #(.DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .launch       (launch),
    .br_valid     (br_valid),
    .br_cond      (br_cond),
    .push_valid   (push_valid),
    .done_valid   (done_valid),
    .active_mask  (active_mask),
    .depth        (depth),
    .stack_full   (stack_full),
    .overflow     (overflow),
    .underflow    (underflow),
    .thread_state (thread_state),
    .running      (running)
);

// File: tb/warp_reconv_stack_tb.sv
`timescale 1ns/1ps
module warp_reconv_stack_tb;
    localparam int TB_DEPTH = 4;
    localparam int CW = $clog2(TB_DEPTH + 1);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        launch = 1'b0;
    logic [21:0] launch_pc = '0;
    logic [31:0] launch_mask = '0;
    logic        br_valid = 1'b0;
    logic [31:0] br_cond = '0;
    logic [21:0] br_target = '0;
    logic [21:0] br_next_pc = '0;
    logic        push_valid = 1'b0;
    logic [21:0] push_pc = '0;
    logic [2:0]  push_type = '0;
    logic        done_valid = 1'b0;
    logic [1:0]  done_kind = '0;
    logic [21:0] pc;
    logic [31:0] active_mask;
    logic [CW-1:0] depth;
    logic        stack_empty, stack_full, overflow, underflow, running;
    logic [63:0] thread_state;

    always #4 clk = ~clk;

    warp_reconv_stack #(.DEPTH(TB_DEPTH)) u_dut (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_pc(launch_pc),
        .launch_mask(launch_mask), .br_valid(br_valid), .br_cond(br_cond),
        .br_target(br_target), .br_next_pc(br_next_pc), .push_valid(push_valid),
        .push_pc(push_pc), .push_type(push_type), .done_valid(done_valid),
        .done_kind(done_kind), .pc(pc), .active_mask(active_mask), .depth(depth),
        .stack_empty(stack_empty), .stack_full(stack_full), .overflow(overflow),
        .underflow(underflow), .thread_state(thread_state), .running(running)
    );

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    // reference model built from the requirements
    localparam int M_IDLE = 0, M_RUN = 1, M_DRAIN = 2, M_FAULT = 3;
    int          m_fsm = M_IDLE;
    logic [21:0] m_pc = '0;
    logic [31:0] m_mask = '0;
    bit          m_ovf = 1'b0, m_unf = 1'b0;
    logic [1:0]  m_st [32];
    logic [21:0] ms_pc [TB_DEPTH];
    logic [31:0] ms_mask [TB_DEPTH];
    logic [2:0]  ms_kind [TB_DEPTH];
    int          m_sp = 0;

    typedef struct {
        logic [21:0] pc;
        logic [31:0] mask;
        int          depth;
        logic        ovf, unf, run, full, empty;
        logic [63:0] ts;
    } exp_t;

    exp_t  exp_q [$];
    string tag_q [$];
    exp_t  cur_e;
    string cur_tag;

    initial begin
        for (int i = 0; i < 32; i++) m_st[i] = 2'd0;
    end

    task automatic m_push(input logic [2:0] k, input logic [21:0] p, input logic [31:0] m);
        ms_kind[m_sp] = k;
        ms_pc[m_sp] = p;
        ms_mask[m_sp] = m;
        m_sp++;
    endtask

    task automatic m_pop();
        logic [31:0] nm;
        logic [2:0]  k;
        m_sp--;
        k = ms_kind[m_sp];
        nm = '0;
        for (int i = 0; i < 32; i++) begin
            if (ms_mask[m_sp][i]) begin
                if ((k == 3'd2 || k == 3'd3) && m_st[i] == 2'd2) m_st[i] = 2'd0;
                if (k == 3'd4 && m_st[i] == 2'd1) m_st[i] = 2'd0;
                nm[i] = (m_st[i] != 2'd3);
            end
        end
        m_pc = ms_pc[m_sp];
        m_mask = nm;
        m_fsm = (nm != '0) ? M_RUN : M_DRAIN;
    endtask

    task automatic m_step();
        logic [31:0] tk, nt;
        if (launch) begin
            m_pc = launch_pc; m_mask = launch_mask; m_sp = 0;
            m_ovf = 1'b0; m_unf = 1'b0; m_fsm = M_RUN;
            for (int i = 0; i < 32; i++) m_st[i] = 2'd0;
        end else if (m_fsm == M_RUN) begin
            if (done_valid) begin
                if (done_kind != 2'd0)
                    for (int i = 0; i < 32; i++) if (m_mask[i]) m_st[i] = done_kind;
                if (m_sp == 0) begin
                    m_unf = 1'b1; m_mask = '0; m_fsm = M_FAULT;
                end else m_pop();
            end else if (br_valid) begin
                tk = m_mask & br_cond;
                nt = m_mask & ~br_cond;
                if (tk == '0) m_pc = br_next_pc;
                else if (nt == '0) m_pc = br_target;
                else if (m_sp == TB_DEPTH) begin
                    m_ovf = 1'b1; m_mask = '0; m_fsm = M_FAULT;
                end else begin
                    m_push(push_type, br_next_pc, nt);
                    m_pc = br_target; m_mask = tk;
                end
            end else if (push_valid) begin
                if (m_sp == TB_DEPTH) begin
                    m_ovf = 1'b1; m_mask = '0; m_fsm = M_FAULT;
                end else m_push(push_type, push_pc, m_mask);
            end
        end else if (m_fsm == M_DRAIN) begin
            if (m_sp == 0) begin
                m_mask = '0; m_fsm = M_IDLE;
            end else m_pop();
        end
    endtask

    function automatic exp_t m_snapshot();
        exp_t e;
        e.pc = m_pc; e.mask = m_mask; e.depth = m_sp;
        e.ovf = m_ovf; e.unf = m_unf; e.run = (m_fsm == M_RUN);
        e.full = (m_sp == TB_DEPTH); e.empty = (m_sp == 0);
        for (int i = 0; i < 32; i++) e.ts[2*i +: 2] = m_st[i];
        return e;
    endfunction

    // driver: one command per cycle, expected result queued for the next edge
    task automatic drive(input string tag, input bit ln, input logic [21:0] lpc,
                         input logic [31:0] lmask, input bit bv, input logic [31:0] bc,
                         input logic [21:0] bt, input logic [21:0] bn, input bit pv,
                         input logic [21:0] ppc, input logic [2:0] ty, input bit dv,
                         input logic [1:0] dk);
        @(negedge clk);
        launch = ln; launch_pc = lpc; launch_mask = lmask;
        br_valid = bv; br_cond = bc; br_target = bt; br_next_pc = bn;
        push_valid = pv; push_pc = ppc; push_type = ty;
        done_valid = dv; done_kind = dk;
        m_step();
        exp_q.push_back(m_snapshot());
        tag_q.push_back(tag);
    endtask

    task automatic t_idle(input string tag);
        drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic t_launch(input string tag, input logic [21:0] p, input logic [31:0] m);
        drive(tag, 1, p, m, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask
    task automatic t_branch(input string tag, input logic [31:0] c, input logic [21:0] t,
                            input logic [21:0] n, input logic [2:0] ty);
        drive(tag, 0, 0, 0, 1, c, t, n, 0, 0, ty, 0, 0);
    endtask
    task automatic t_push(input string tag, input logic [21:0] p, input logic [2:0] ty);
        drive(tag, 0, 0, 0, 0, 0, 0, 0, 1, p, ty, 0, 0);
    endtask
    task automatic t_done(input string tag, input logic [1:0] k);
        drive(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, k);
    endtask

    // monitor: compare after every edge that has a queued expectation
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            cur_e = exp_q.pop_front();
            cur_tag = tag_q.pop_front();
            checks++;
            if (pc !== cur_e.pc || active_mask !== cur_e.mask || int'(depth) != cur_e.depth ||
                overflow !== cur_e.ovf || underflow !== cur_e.unf || running !== cur_e.run ||
                stack_full !== cur_e.full || stack_empty !== cur_e.empty ||
                thread_state !== cur_e.ts) begin
                failures++;
                $display("FAIL %s: actual pc=%h mask=%h depth=%0d ovf=%b unf=%b run=%b full=%b empty=%b ts=%h expected pc=%h mask=%h depth=%0d ovf=%b unf=%b run=%b full=%b empty=%b ts=%h",
                         cur_tag, pc, active_mask, depth, overflow, underflow, running,
                         stack_full, stack_empty, thread_state, cur_e.pc, cur_e.mask,
                         cur_e.depth, cur_e.ovf, cur_e.unf, cur_e.run, cur_e.full,
                         cur_e.empty, cur_e.ts);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (pc !== '0 || active_mask !== '0 || depth !== '0 || stack_empty !== 1'b1 ||
            overflow !== 1'b0 || underflow !== 1'b0 || thread_state !== '0 || running !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset: actual pc=%h mask=%h depth=%0d ts=%h run=%b expected all zero, empty=1",
                     pc, active_mask, depth, thread_state, running);
        end
        rst_n = 1'b1;
        t_idle("R1 idle after reset");

        t_launch("R2 launch", 22'h100, 32'hFFFF_FFFF);
        t_branch("R3 all taken", 32'hFFFF_FFFF, 22'h200, 22'h101, 3'd1);
        t_branch("R3 none taken", 32'h0, 22'h300, 22'h201, 3'd1);
        t_launch("R2 relaunch", 22'h10, 32'h0000_FFFF);
        t_branch("R3 inactive cond bits ignored", 32'hFFFF_0000, 22'h80, 22'h11, 3'd1);
        t_branch("R4 divergent branch", 32'h0000_00FF, 22'h90, 22'h12, 3'd1);
        t_push("R5 explicit call push", 22'h300, 3'd2);
        t_done("R9 return revived by call pop", 2'd2);
        t_done("R6 pop branch record", 2'd0);
        t_done("R12 underflow", 2'd0);
        t_branch("R13 branch ignored in fault", 32'h1, 22'h5, 22'h6, 3'd1);
        t_push("R13 push ignored in fault", 22'h7, 3'd1);
        t_launch("R2 launch clears fault", 22'h0, 32'h0000_000F);

        t_push("R5 joinat push", 22'h40, 3'd6);
        t_branch("R4 divergent inner", 32'h3, 22'h20, 22'h8, 3'd1);
        t_done("R7 exit code on active threads", 2'd3);
        t_done("R8 exited threads removed on pop", 2'd1);

        t_launch("R2 launch", 22'h0, 32'h0000_000F);
        t_push("R5 prebreak push", 22'h44, 3'd4);
        t_done("R9 break revived by prebreak pop", 2'd1);

        t_launch("R2 launch", 22'h0, 32'h0000_000F);
        t_push("R5 prebreak push", 22'h70, 3'd4);
        t_branch("R4 divergent", 32'h3, 22'h21, 22'h9, 3'd1);
        t_push("R5 branch push", 22'h80, 3'd1);
        t_done("R10 empty restored mask enters drain", 2'd3);
        t_done("R10 drain pops to live record, R13 done ignored", 2'd2);
        t_done("R10 pop to dead record", 2'd3);
        t_idle("R10 drain reaches empty stack");
        t_idle("R10 idle holds");

        t_launch("R2 launch", 22'h5, 32'h0000_00FF);
        t_push("R5 push 1", 22'h31, 3'd1);
        t_push("R5 push 2", 22'h32, 3'd2);
        t_push("R5 push 3", 22'h33, 3'd3);
        t_push("R5 push 4 full", 22'h34, 3'd4);
        t_push("R11 overflow", 22'h35, 3'd5);
        t_branch("R13 ignored after overflow", 32'h1, 22'h36, 22'h37, 3'd1);

        t_launch("R2 launch", 22'h6, 32'h0000_000F);
        t_push("R5 call-limit push", 22'h99, 3'd3);
        drive("R13 done beats branch", 0, 0, 0, 1, 32'h1, 22'h50, 22'h51, 1, 22'h52, 3'd1, 1, 2'd0);
        t_push("R5 push before priority", 22'h60, 3'd1);
        drive("R13 launch beats done", 1, 22'h77, 32'h0000_00F0, 0, 0, 0, 0, 0, 0, 0, 1, 2'd3);
        t_idle("R13 final idle");

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule